// File: doc/BRIEF.md
# I2C Register Target with Persistent Sub-Address Pointer

This block lets an external I2C controller read and write a 256-location byte register space that lives outside the block. It watches SCL and SDA through synchronizers clocked by the system clock. It recognises START and STOP conditions and answers only to its own fixed 7-bit bus address. It pulls SDA low through an open-drain enable and never drives the line high.

In a write transfer, the first byte after the bus address sets an internal sub-address pointer. Each later byte becomes one write strobe on the storage port, aimed at the pointer, and the pointer then advances. A read transfer fetches from the pointer, and each fetch also advances the pointer. The pointer survives STOP and repeated START. This makes three forms possible: a pointer-only write, a pointer-then-repeated-START read, and a bare read that continues from wherever the last access left off. The pointer is also the read address shown to the storage.

When the host enable input is high, every completed register write also produces a one-cycle notification pulse.

The storage port has no back-pressure, because the block does not stretch the clock. A write strobe is valid-only and must be accepted in the cycle it appears. The read path is combinational: `rd_data` must show the contents at `rd_addr` in the same cycle.

Top module: `i2c_subaddr_target`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts address reception from any state, including a repeated START inside a transfer. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The bus address is received MSB first, followed by a direction bit (1 = read, 0 = write). When the 7 address bits equal 0x5C, the block pulls SDA low during the 9th clock.
- R3: In a write transfer, the first byte after the address loads the pointer, is acknowledged, and produces no write strobe.
- R4: Each further write byte is acknowledged and produces exactly one single-cycle `wr_valid`, with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The pointer then increases by one.
- R5: A read transfer returns, MSB first, the byte at the current pointer. The pointer increases by one for each byte fetched, and a read with no pointer byte before it continues from the pointer left by earlier traffic.
- R6: After a read byte, a controller ACK (SDA low in the 9th clock) makes the block send the next byte. A controller NACK makes it release SDA and stay silent until the next START.
- R7: `wr_irq` pulses for one cycle together with each `wr_valid` while `irq_en` is high, and never pulses otherwise.
- R8: If the received address does not equal 0x5C, the block does not acknowledge, issues no writes, leaves the pointer unchanged and keeps SDA released until the next START.
- R9: The pointer is 8 bits wide, is 0x00 after reset, wraps from 0xFF to 0x00, and keeps its value across STOP and repeated START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| irq_en | input | 1 | Enables the write notification pulse |
| wr_valid | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 8 | Write location |
| wr_data | output | 8 | Write byte |
| rd_addr | output | 8 | Current pointer; read location |
| rd_data | input | 8 | Contents at `rd_addr`, same cycle |
| wr_irq | output | 1 | Write notification pulse |

## Verification
Three things happen in the same clock when a data byte completes: the write strobe, the notification pulse and the pointer step. At location 0xFF the pointer wrap falls in that same cycle. The bench provokes this with a burst write that starts at 0xFE and crosses the top of the space, then reads back across the same boundary. A monitor compares every strobe, with its address and data, against a queue filled by the controller model. In the same cycle it checks the notification pulse against the enable, and it confirms that the pointer ends at 0x01.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK,
    ST_RX,
    ST_RX_END,
    ST_TX,
    ST_MACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    SH_HOLD,
    SH_LOAD,
    SH_RX,
    SH_TX
  } sh_op_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign scl_s     = synced[1];
  assign sda_s     = synced[0];
  assign scl_rise  = synced[1] & ~prev[1];
  assign scl_fall  = ~synced[1] & prev[1];
  assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];

endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2c_tgt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sh_op_e        op,
  input  logic [W-1:0]  ld_data,
  input  logic          bit_in,
  output logic [W-1:0]  sh_q,
  output logic          last
);

  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else begin
      unique case (op)
        SH_LOAD: begin
          sh_q  <= ld_data;
          cnt_q <= '0;
        end
        SH_RX: begin
          sh_q  <= {sh_q[W-2:0], bit_in};
          cnt_q <= cnt_q + CW'(1);
        end
        SH_TX: begin
          sh_q  <= {sh_q[W-2:0], 1'b1};
          cnt_q <= cnt_q + CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign last = (cnt_q == CW'(W - 1));

endmodule

// File: rtl/i2c_subaddr_target.sv
module i2c_subaddr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5C,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          irq_en,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_irq
);

  localparam int DW = 8;

  tgt_state_e    state;
  sh_op_e        op;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] full_byte;
  logic          last;
  logic          match_q, rw_q, rd_mode, ptr_phase, mack_q;
  logic [AW-1:0] ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_byte_shifter #(.W(DW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .ld_data (rd_data),
    .bit_in  (sda_s),
    .sh_q    (sh_q),
    .last    (last)
  );

  assign full_byte = {sh_q[DW-2:0], sda_s};

  always_comb begin
    op = SH_HOLD;
    if (start_det) begin
      op = SH_LOAD;
    end else if (!stop_det) begin
      unique case (state)
        ST_ADDR, ST_RX: if (scl_rise)            op = SH_RX;
        ST_ACK:         if (scl_fall)            op = SH_LOAD;
        ST_TX:          if (scl_fall && !last)   op = SH_TX;
        ST_MACK:        if (scl_fall && mack_q)  op = SH_LOAD;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      match_q   <= 1'b0;
      rw_q      <= 1'b0;
      rd_mode   <= 1'b0;
      ptr_phase <= 1'b0;
      mack_q    <= 1'b0;
      ptr       <= '0;
      wr_valid  <= 1'b0;
      wr_irq    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_valid <= 1'b0;
      wr_irq   <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;
      end else if (stop_det) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise && last) begin
            match_q <= (full_byte[DW-1:1] == DEV_ADDR);
            rw_q    <= full_byte[0];
            state   <= ST_ADDR_END;
          end
          ST_ADDR_END: if (scl_fall) begin
            if (match_q) begin
              state     <= ST_ACK;
              rd_mode   <= rw_q;
              ptr_phase <= ~rw_q;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ACK: if (scl_fall) begin
            if (rd_mode) begin
              state <= ST_TX;
              ptr   <= ptr + AW'(1);
            end else begin
              state <= ST_RX;
            end
          end
          ST_RX: if (scl_rise && last) begin
            state <= ST_RX_END;
            if (ptr_phase) begin
              ptr       <= full_byte[AW-1:0];
              ptr_phase <= 1'b0;
            end else begin
              wr_valid <= 1'b1;
              wr_irq   <= irq_en;
              wr_addr  <= ptr;
              wr_data  <= full_byte;
              ptr      <= ptr + AW'(1);
            end
          end
          ST_RX_END: if (scl_fall) state <= ST_ACK;
          ST_TX: if (scl_fall && last) state <= ST_MACK;
          ST_MACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                state <= ST_TX;
                ptr   <= ptr + AW'(1);
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_addr = ptr;
  assign sda_oe  = (state == ST_ACK) || (state == ST_TX && !sh_q[DW-1]);

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR)); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R1
  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R2
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R4
  AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (rd_addr == wr_addr + AW'(1))); // R9
  AST_IRQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq |-> wr_valid); // R7

endmodule

// File: tb/tb_i2c_subaddr_target.sv
`timescale 1ns/1ps
module tb_i2c_subaddr_target;

  localparam int QTR = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       irq_en = 1'b0;
  logic       sda_oe, wr_valid, wr_irq;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic       sda_line;
  logic [7:0] bmem [256];
  logic [15:0] exp_q [$];
  logic [15:0] e;
  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = bmem[rd_addr];

  i2c_subaddr_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .irq_en(irq_en), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_irq(wr_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // storage model and per-cycle comparison of the write port
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected write", int'(wr_addr), 0);
        else begin
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R4 write addr/data", int'({wr_addr, wr_data}), int'(e));
        end
        chk(wr_irq == irq_en, "R7 notify with write", int'(wr_irq), int'(irq_en));
        if (wr_irq) irq_cnt++;
        bmem[wr_addr] = wr_data;
      end else if (wr_irq) begin
        chk(0, "R7 notify without write", 1, 0);
      end
    end
  end

  task automatic qw();
    repeat (QTR) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw();
      scl_m = 1'b1; qw(); qw();
      scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    acked = ~sda_line; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; qw();
      scl_m = 1'b1; qw();
      b = {b[6:0], sda_line}; qw();
      scl_m = 1'b0; qw();
    end
    sda_m = mack ? 1'b0 : 1'b1; qw();
    scl_m = 1'b1; qw(); qw();
    scl_m = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  task automatic put(input logic [7:0] b, input bit exp_ack, input string req);
    bit a;
    send_byte(b, a);
    chk(a == exp_ack, req, int'(a), int'(exp_ack));
  endtask

  task automatic get(input bit mack, input logic [7:0] exp, input string req);
    logic [7:0] b;
    recv_byte(mack, b);
    chk(b == exp, req, int'(b), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int irq_base;
    logic [7:0] exp_b;
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(sda_oe == 1'b0, "R1 reset sda released", int'(sda_oe), 0);
    chk(wr_valid == 1'b0 && wr_irq == 1'b0, "R7 reset no strobe", int'(wr_valid), 0);
    chk(rd_addr == 8'h00, "R9 reset pointer", int'(rd_addr), 0);

    // burst write with notification enabled
    irq_en = 1'b1;
    bus_start();
    put(8'hB8, 1, "R2 address ack (write)");
    put(8'h10, 1, "R3 pointer byte ack");
    chk(rd_addr == 8'h10, "R3 pointer loaded", int'(rd_addr), 'h10);
    exp_q.push_back(16'h10A1); put(8'hA1, 1, "R4 data ack");
    exp_q.push_back(16'h11B2); put(8'hB2, 1, "R4 data ack");
    exp_q.push_back(16'h12C3); put(8'hC3, 1, "R4 data ack");
    bus_stop();
    chk(rd_addr == 8'h13, "R4 pointer advanced", int'(rd_addr), 'h13);
    chk(irq_cnt == 3, "R7 notify count enabled", irq_cnt, 3);
    chk(sda_oe == 1'b0, "R1 released after stop", int'(sda_oe), 0);

    // notification disabled
    irq_en = 1'b0;
    irq_base = irq_cnt;
    bus_start();
    put(8'hB8, 1, "R2 address ack");
    put(8'h30, 1, "R3 pointer byte ack");
    exp_q.push_back(16'h3044); put(8'h44, 1, "R4 data ack");
    bus_stop();
    chk(irq_cnt == irq_base, "R7 no notify when disabled", irq_cnt, irq_base);

    // bare read continues from pointer 0x31
    bus_start();
    put(8'hB9, 1, "R2 address ack (read)");
    get(1, bmem[8'h31], "R5 read current pointer");
    get(0, bmem[8'h32], "R5 read next byte");
    chk(sda_oe == 1'b0, "R6 released after NACK", int'(sda_oe), 0);
    bus_stop();
    chk(rd_addr == 8'h33, "R5 pointer after read", int'(rd_addr), 'h33);

    // combined: pointer write, repeated START, read
    bus_start();
    put(8'hB8, 1, "R2 address ack");
    put(8'h40, 1, "R3 pointer byte ack");
    bus_start();
    chk(rd_addr == 8'h40, "R9 pointer kept at repeated START", int'(rd_addr), 'h40);
    put(8'hB9, 1, "R1 repeated START address ack");
    get(1, bmem[8'h40], "R6 ACK continues");
    get(1, bmem[8'h41], "R6 ACK continues");
    get(0, bmem[8'h42], "R5 last read byte");
    bus_stop();
    chk(rd_addr == 8'h43, "R5 pointer after burst", int'(rd_addr), 'h43);

    // foreign address is ignored
    bus_start();
    put(8'hBA, 0, "R8 no ack on mismatch");
    put(8'h00, 0, "R8 ignored byte");
    put(8'h77, 0, "R8 ignored byte");
    bus_stop();
    chk(rd_addr == 8'h43, "R8 pointer unchanged", int'(rd_addr), 'h43);

    // write burst across the top of the space
    irq_en = 1'b1;
    irq_base = irq_cnt;
    bus_start();
    put(8'hB8, 1, "R2 address ack");
    put(8'hFE, 1, "R3 pointer byte ack");
    exp_q.push_back(16'hFE11); put(8'h11, 1, "R4 data ack");
    exp_q.push_back(16'hFF22); put(8'h22, 1, "R4 data ack");
    exp_q.push_back(16'h0033); put(8'h33, 1, "R9 data ack after wrap");
    bus_stop();
    chk(rd_addr == 8'h01, "R9 pointer wrapped", int'(rd_addr), 'h01);
    chk(irq_cnt == irq_base + 3, "R7 notify count at wrap", irq_cnt, irq_base + 3);

    // read across the top of the space
    bus_start();
    put(8'hB8, 1, "R2 address ack");
    put(8'hFF, 1, "R3 pointer byte ack");
    bus_start();
    put(8'hB9, 1, "R2 address ack (read)");
    exp_b = 8'h22;
    get(1, exp_b, "R9 read at 0xFF");
    exp_b = 8'h33;
    get(0, exp_b, "R9 read wrapped to 0x00");
    bus_stop();
    chk(rd_addr == 8'h01, "R9 pointer after read wrap", int'(rd_addr), 'h01);

    // address only, then STOP: pointer untouched
    bus_start();
    put(8'hB8, 1, "R2 address ack");
    bus_stop();
    chk(rd_addr == 8'h01, "R1 STOP before pointer byte", int'(rd_addr), 'h01);

    repeat (20) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule